// File: doc/BRIEF.md
# Single-Line Interrupt Trigger Controller

This block takes one asynchronous interrupt request from outside the clock domain and turns it into a clean, maskable interrupt for a parent controller. Software uses a 2-bit field to choose whether the request counts as an active-low level, an active-high level, a falling edge or a rising edge. Each qualifying event is held in a sticky pending flag. Software clears that flag by writing a one to it. An enable bit masks the flag before it reaches the output.

Software reaches the block through a simple register port: an address, a write strobe, write data and combinational read data. The port has three registers: trigger control, pending and enable. A build parameter picks one of two address layouts. In both layouts the control register sits at offset zero. The other two registers swap places between the layouts.

Top module: `irq_line_ctrl`

## Requirements
- R1: Control bits [1:0] select the trigger: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge.
- R2: Every bit of the control register reads back exactly as written, including the bits above [1:0].
- R3: Bit 0 of the pending register is the pending flag. A write with bit 0 = 1 clears it. A write with bit 0 = 0 leaves it unchanged.
- R4: `irq_out` equals the AND of the pending flag and enable bit 0, delayed by one clock register. Enable = 0 masks the output.
- R5: With `SWAP_LAYOUT` = 0, control is at offset 0x00, pending at 0x04 and enable at 0x08.
- R6: With `SWAP_LAYOUT` = 1, control stays at 0x00, enable is at 0x04 and pending is at 0x08.
- R7: In a level mode the pending flag is set on every cycle that the synchronised input is at its active level. A clear written while the level is still active leaves the flag set.
- R8: If an event and a clear of the pending flag happen on the same clock edge, the flag ends up set.
- R9: The request passes through two synchronising flops. After an input change, the pending flag is set on the third rising clock edge and `irq_out` rises on the fourth.
- R10: Reset clears the control, pending and enable registers and `irq_out`. Reads of any unmapped offset return zero, and writes to unmapped offsets change nothing.
- R11: In an edge mode only a transition in the selected direction sets the flag. A steady input, or a transition in the other direction, does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| req_async | input | 1 | External interrupt request, asynchronous |
| irq_out | output | 1 | Masked interrupt towards the parent controller |

## Verification
Every piece of internal state has a port where a fault in it becomes visible:
- A corrupted pending flag appears on the next read of the pending offset, and on `irq_out` one edge later if enable is set.
- A wrong sample in the synchroniser or the delay flop shifts the moment the flag sets away from the third edge after an input change. A transition in the wrong direction can also raise the flag when it should not.
- A trigger field decoded wrongly turns a quiet input into a pending event, or the reverse, within three cycles.
- A wrong priority between set and clear loses an event only on the exact edge where both happen. The bench therefore lines a write of one up against that edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned OFS_CTRL = 32'h00;
    localparam int unsigned OFS_LO   = 32'h04;
    localparam int unsigned OFS_HI   = 32'h08;

    typedef enum logic [1:0] {
        TRIG_LVL_LOW  = 2'd0,
        TRIG_FALL     = 2'd1,
        TRIG_LVL_HIGH = 2'd2,
        TRIG_RISE     = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_PEND = 2'd2,
        SEL_EN   = 2'd3
    } reg_sel_e;

    // Map a byte offset to a register; swap selects the alternate layout.
    function automatic reg_sel_e addr_decode(input logic [31:0] ofs, input bit swap);
        reg_sel_e sel;
        if (ofs == OFS_CTRL)
            sel = SEL_CTRL;
        else if (ofs == OFS_LO)
            sel = swap ? SEL_EN : SEL_PEND;
        else if (ofs == OFS_HI)
            sel = swap ? SEL_PEND : SEL_EN;
        else
            sel = SEL_NONE;
        return sel;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain_q[g] <= 1'b0;
                else if (g == 0)
                    chain_q[g] <= din;
                else
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  logic       sample,
    output logic       sample_prev,
    output logic       event_hit
);
    always_ff @(posedge clk) begin
        if (rst)
            sample_prev <= 1'b0;
        else
            sample_prev <= sample;
    end

    always_comb begin
        unique case (mode)
            TRIG_LVL_LOW:  event_hit = ~sample;
            TRIG_LVL_HIGH: event_hit = sample;
            TRIG_FALL:     event_hit = sample_prev & ~sample;
            TRIG_RISE:     event_hit = ~sample_prev & sample;
            default:       event_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter bit SWAP_LAYOUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              event_hit,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              pend_q,
    output logic              en_q
);
    reg_sel_e sel;
    logic     clr_req;

    assign sel     = addr_decode(32'(addr), SWAP_LAYOUT);
    assign clr_req = we && (sel == SEL_PEND) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_q   <= 1'b0;
        end else if (we) begin
            if (sel == SEL_CTRL) ctrl_q <= wdata;
            if (sel == SEL_EN)   en_q   <= wdata[0];
        end
    end

    // Set has priority over the write-one clear.
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (event_hit)
            pend_q <= 1'b1;
        else if (clr_req)
            pend_q <= 1'b0;
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = ctrl_q;
            SEL_PEND: rdata = {{(DATA_W-1){1'b0}}, pend_q};
            SEL_EN:   rdata = {{(DATA_W-1){1'b0}}, en_q};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter bit SWAP_LAYOUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              req_async,
    output logic              irq_out
);
    logic              req_sync;
    logic              req_prev;
    logic              evt;
    logic [DATA_W-1:0] ctrl_q;
    logic              pend_q;
    logic              en_q;
    trig_mode_e        trig;

    assign trig = trig_mode_e'(ctrl_q[1:0]);

    irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (req_async),
        .dout (req_sync)
    );

    irqc_detect u_detect (
        .clk         (clk),
        .rst         (rst),
        .mode        (trig),
        .sample      (req_sync),
        .sample_prev (req_prev),
        .event_hit   (evt)
    );

    irqc_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SWAP_LAYOUT (SWAP_LAYOUT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .event_hit (evt),
        .rdata     (bus_rdata),
        .ctrl_q    (ctrl_q),
        .pend_q    (pend_q),
        .en_q      (en_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_out <= 1'b0;
        else
            irq_out <= pend_q & en_q;
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter bit SWAP_LAYOUT = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_out,
    input logic              pend_q,
    input logic              en_q,
    input logic [1:0]        trig,
    input logic              req_sync,
    input logic              req_prev,
    input logic              evt
);
    reg_sel_e chk_sel;
    assign chk_sel = addr_decode(32'(bus_addr), SWAP_LAYOUT);

    // R4: output is the registered AND of flag and enable
    a_r4_irq_registered: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(pend_q & en_q)));

    // R3: a write of zero to the pending register keeps a set flag
    a_r3_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (pend_q && bus_we && chk_sel == SEL_PEND && !bus_wdata[0]) |=> pend_q);

    // R3: a write of one clears the flag when no event competes
    a_r3_one_write_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_we && chk_sel == SEL_PEND && bus_wdata[0] && !evt) |=> !pend_q);

    // R8: an event always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        evt |=> pend_q);

    // R11: steady input in an edge mode raises nothing
    a_r11_edge_quiet: assert property (@(posedge clk) disable iff (rst)
        (trig[0] && (req_sync == req_prev) && !pend_q) |=> !pend_q);

    // R10: unmapped offsets read as zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (chk_sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

bind irq_line_ctrl irqc_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SWAP_LAYOUT (SWAP_LAYOUT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .trig      (ctrl_q[1:0]),
    .req_sync  (req_sync),
    .req_prev  (req_prev),
    .evt       (evt)
);

// File: tb/tb_irq_line_ctrl.sv
`timescale 1ns/1ps
module tb_irq_line_ctrl;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_CTRL = 8'h00;
    localparam logic [AW-1:0] A_PEND = 8'h04;
    localparam logic [AW-1:0] A_EN   = 8'h08;

    // {mode[1:0], init, fin, en, exp_pend, exp_irq}
    localparam logic [6:0] VEC [0:8] = '{
        7'b00_1_0_1_1_1,  // low level reached
        7'b00_1_1_1_0_0,  // low level never reached
        7'b10_0_1_0_1_0,  // high level, masked
        7'b10_0_0_1_0_0,  // high level never reached
        7'b11_0_1_1_1_1,  // rising edge
        7'b11_1_0_1_0_0,  // falling transition in rising mode
        7'b01_1_0_1_1_1,  // falling edge
        7'b01_0_1_1_0_0,  // rising transition in falling mode
        7'b10_1_0_1_1_1   // clear while high level active re-sets
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0, s_addr = '0;
    logic          we = 1'b0, s_we = 1'b0;
    logic [DW-1:0] wdata = '0, s_wdata = '0;
    logic [DW-1:0] rdata, s_rdata;
    logic          req = 1'b0;
    logic          irq, s_irq;
    int            n_chk = 0;
    int            n_bad = 0;
    logic [DW-1:0] rv;

    always #2.5 clk = ~clk;

    irq_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SWAP_LAYOUT(1'b0)) dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .req_async(req), .irq_out(irq));

    irq_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SWAP_LAYOUT(1'b1)) dut_swap (
        .clk(clk), .rst(rst), .bus_addr(s_addr), .bus_we(s_we), .bus_wdata(s_wdata),
        .bus_rdata(s_rdata), .req_async(req), .irq_out(s_irq));

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); addr = a; we = 1'b0; #1; d = rdata;
    endtask

    task automatic s_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); s_addr = a; s_wdata = d; s_we = 1'b1;
        @(negedge clk); s_we = 1'b0;
    endtask

    task automatic s_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); s_addr = a; s_we = 1'b0; #1; d = s_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R10: reset state, read while reset is held
        repeat (3) @(posedge clk);
        rd(A_CTRL, rv); check("R10 ctrl reset", rv, '0);
        rd(A_PEND, rv); check("R10 pend reset", rv, '0);
        rd(A_EN, rv);   check("R10 en reset", rv, '0);
        check("R10 irq reset", {31'd0, irq}, '0);
        @(negedge clk); rst = 1'b0;

        // R2: full control register readback, R1 field at 2 (high level, req low)
        wr(A_CTRL, 32'hA5A5_5A5E);
        rd(A_CTRL, rv); check("R2 ctrl readback", rv, 32'hA5A5_5A5E);

        // R10: unmapped offsets
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        rd(8'h0C, rv);  check("R10 unmapped 0x0C", rv, '0);
        rd(8'h05, rv);  check("R10 unmapped 0x05", rv, '0);
        rd(A_CTRL, rv); check("R10 ctrl untouched", rv, 32'hA5A5_5A5E);
        rd(A_EN, rv);   check("R10 en untouched", rv, '0);

        // R9: latency in rising mode, R5 default offsets
        wr(A_CTRL, 32'd3);
        wr(A_EN, 32'd1);
        idle(4);
        wr(A_PEND, 32'd1);
        rd(A_PEND, rv); check("R5 pend clear at 0x04", rv, '0);
        rd(A_EN, rv);   check("R5 enable at 0x08", rv, 32'd1);
        addr = A_PEND;
        @(negedge clk); req = 1'b1;
        @(posedge clk); @(negedge clk); #1 check("R9 pend after edge1", rdata, '0);
        @(posedge clk); @(negedge clk); #1 check("R9 pend after edge2", rdata, '0);
        @(posedge clk); @(negedge clk); #1 check("R9 pend after edge3", rdata, 32'd1);
        check("R9 irq after edge3", {31'd0, irq}, '0);
        @(posedge clk); @(negedge clk); #1 check("R9 irq after edge4", {31'd0, irq}, 32'd1);

        // R3: zero write keeps the flag, one write clears it (input steady high)
        wr(A_PEND, 32'hFFFF_FFFE);
        rd(A_PEND, rv); check("R3 zero write keeps", rv, 32'd1);
        wr(A_PEND, 32'd1);
        rd(A_PEND, rv); check("R3 one write clears", rv, '0);
        idle(1);
        check("R4 irq low after clear", {31'd0, irq}, '0);

        // R8: clear on the very edge an event sets
        @(negedge clk); req = 1'b0;
        idle(5);
        wr(A_PEND, 32'd1);
        @(negedge clk); req = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk); addr = A_PEND; wdata = 32'd1; we = 1'b1;
        @(posedge clk); @(negedge clk); we = 1'b0; #1;
        check("R8 set wins over clear", rdata, 32'd1);

        // R7: clear while high level active stays set; clears once inactive
        wr(A_CTRL, 32'd2);
        idle(3);
        wr(A_PEND, 32'd1);
        rd(A_PEND, rv); check("R7 level re-sets after clear", rv, 32'd1);
        @(negedge clk); req = 1'b0;
        idle(5);
        wr(A_PEND, 32'd1);
        rd(A_PEND, rv); check("R7 level inactive clears", rv, '0);

        // R1 R4 R11: vector walk over trigger modes
        for (int i = 0; i < 9; i++) begin
            wr(A_CTRL, {30'd0, VEC[i][6:5]});
            wr(A_EN, {31'd0, VEC[i][2]});
            @(negedge clk); req = VEC[i][4];
            idle(6);
            wr(A_PEND, 32'd1);
            @(negedge clk); req = VEC[i][3];
            idle(6);
            rd(A_PEND, rv);
            check($sformatf("R1 R11 vec%0d pend", i), rv, {31'd0, VEC[i][1]});
            check($sformatf("R4 vec%0d irq", i), {31'd0, irq}, {31'd0, VEC[i][0]});
        end

        // R6: alternate layout
        @(negedge clk); req = 1'b1;
        s_wr(A_CTRL, 32'd2);
        s_wr(8'h04, 32'd1);
        idle(5);
        s_rd(8'h08, rv); check("R6 pend at 0x08", rv, 32'd1);
        check("R6 irq swap layout", {31'd0, s_irq}, 32'd1);
        @(negedge clk); req = 1'b0;
        idle(5);
        s_wr(8'h08, 32'd1);
        s_rd(8'h08, rv); check("R6 pend cleared at 0x08", rv, '0);
        s_rd(8'h04, rv); check("R6 enable at 0x04", rv, 32'd1);

        finish_run();
    end
endmodule